// File: doc/BRIEF.md
# Remote-Terminal Command Illegalization Checker

This block sits behind the word decoder of a serial command/response bus terminal operating as a remote terminal. For every received 16-bit command word it decides two things. First, is the command addressed to this terminal? That means its own address or the all-ones broadcast address. Second, has host software declared this particular command illegal?

The decision is a lookup in a 4096-entry, one-bit table. The table index is built from four fields of the command: a broadcast flag, the transmit/receive bit, the subaddress and the word count/mode code. Software can therefore forbid any subset of all possible command combinations. Host software loads the table and a six-bit terminal address register through a simple write port, and it can read both back so that the loaded setup can be self-tested.

The address register carries its own odd parity bit. A register whose parity is wrong makes the terminal deaf to every address and raises an error flag. A port with two terminals uses two instances of this block.

Top module: `rt_illegal_chk`

## Requirements
- R1: The command word is split as address = bits 15:11, T/R = bit 10, subaddress = bits 9:5, word count/mode code = bits 4:0. The table index is {broadcast, T/R, subaddress, word count}, where broadcast is index bit 11 and word count is index bits 4:0.
- R2: A command is addressed (`cmd_addressed` = 1) when the register parity is good and its address field equals the own address (register bits 4:0) or equals 31, the broadcast address. The broadcast index bit is 1 exactly when the address field is 31.
- R3: The address register has its parity in bit 5, and the six bits must hold an odd number of ones. When they do not, `addr_err` is 1 and no command, own or broadcast, is addressed.
- R4: `cmd_illegal` is 1 only when the command is addressed and its table entry is 1 (1 = illegal, 0 = legal).
- R5: `verdict_valid` pulses for one clock, one clock after `cmd_valid`. `cmd_addressed` and `cmd_illegal` change only at that edge and otherwise hold.
- R6: A table write (`host_wr_en` = 1, `host_wr_tbl` = 1, entry value in `host_wdata[0]`) without a coincident lookup is visible on the combinational readback `host_rd_bit` after the next clock edge.
- R7: A table write in the same clock as `cmd_valid` is deferred by one clock. The lookup in that clock sees the old contents, and the readback still shows the old value for one clock.
- R8: An address-register write (`host_wr_en` = 1, `host_wr_tbl` = 0, `host_wdata[5:0]`) is visible on `host_rtaddr` after the next edge, and lookups use it from that clock on.
- R9: After reset the table is all legal, the address register is 0 (so `addr_err` = 1), and `verdict_valid`, `cmd_addressed` and `cmd_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_tbl | input | 1 | 1 = write table entry, 0 = write address register |
| host_addr | input | 12 | Table index for a table write |
| host_wdata | input | 6 | Write data (bit 0 for table, all 6 for register) |
| host_rd_addr | input | 12 | Table index for readback |
| host_rd_bit | output | 1 | Readback of the addressed table entry |
| host_rtaddr | output | 6 | Readback of the address register |
| cmd_valid | input | 1 | Command word present this clock |
| cmd_word | input | 16 | Received command word |
| verdict_valid | output | 1 | One-clock pulse when a verdict is updated |
| cmd_addressed | output | 1 | Last command was for this terminal |
| cmd_illegal | output | 1 | Last command was addressed and illegal |
| addr_err | output | 1 | Address register parity error |

## Verification
The bench builds the block with its default field widths: a 5-bit address, a 5-bit subaddress and a 5-bit word count. With those widths the broadcast value 31 and the full 4096-entry index are reachable, including both halves of the table that differ only in the broadcast bit. Random commands are steered to a small subaddress and word-count range so that table writes and lookups meet often. Directed cases cover a write colliding with a lookup, a register loaded with bad parity, and a programmed own address that is not 5.

// File: rtl/rt_ill_pkg.sv
package rt_ill_pkg;
  localparam int ADDR_W = 5;
  localparam int SA_W   = 5;
  localparam int WC_W   = 5;
  localparam int CMD_W  = ADDR_W + 1 + SA_W + WC_W;
  localparam int IDX_W  = 2 + SA_W + WC_W;
  localparam int RTR_W  = ADDR_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] rta;
    logic              tr;
    logic [SA_W-1:0]   sa;
    logic [WC_W-1:0]   wc;
  } cmd_t;

  function automatic logic is_bcast(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  function automatic logic par_good(input logic [RTR_W-1:0] r);
    return ^r;
  endfunction

  function automatic logic [IDX_W-1:0] mk_index(input cmd_t c);
    return {is_bcast(c.rta), c.tr, c.sa, c.wc};
  endfunction
endpackage

// File: rtl/rt_addr_reg.sv
module rt_addr_reg
  import rt_ill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RTR_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] cmd_rta,
  output logic [RTR_W-1:0]  rtaddr,
  output logic              par_ok,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rtaddr <= '0;
    else if (wr_en) rtaddr <= wdata;
  end

  assign par_ok = par_good(rtaddr);
  assign hit    = par_ok && ((cmd_rta == rtaddr[ADDR_W-1:0]) || is_bcast(cmd_rta));

  // R3: a bad-parity register matches nothing
  a_r3_no_hit_bad_par: assert property (@(posedge clk) disable iff (!rst_n)
    !par_ok |-> !hit);
  // R8: register write lands on next edge
  a_r8_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rtaddr == $past(wdata));
endmodule

// File: rtl/ill_table.sv
module ill_table #(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             lookup,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [DEPTH-1:0] mem;
  logic             pend_vld;
  logic [IDX_W-1:0] pend_idx;
  logic             pend_bit;
  logic             collide;

  assign collide = wr_en && lookup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem      <= '0;
      pend_vld <= 1'b0;
      pend_idx <= '0;
      pend_bit <= 1'b0;
    end else begin
      pend_vld <= collide;
      if (collide) begin
        pend_idx <= wr_idx;
        pend_bit <= wr_bit;
      end
      if (pend_vld)             mem[pend_idx] <= pend_bit;
      if (wr_en && !lookup)     mem[wr_idx]   <= wr_bit;
    end
  end

  assign lk_bit = mem[lk_idx];
  assign rd_bit = mem[rd_idx];

  // R7: a deferred write waits exactly one clock
  a_r7_defer_one: assert property (@(posedge clk) disable iff (!rst_n)
    !collide |=> !pend_vld);
  a_r7_defer_set: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> pend_vld);
  // R7: a colliding write leaves the entry untouched at that edge
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !pend_vld && rd_idx == wr_idx) |=> $stable(rd_bit) || $past(rd_idx) != rd_idx);
endmodule

// File: rtl/rt_illegal_chk.sv
module rt_illegal_chk
  import rt_ill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_tbl,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [RTR_W-1:0]  host_wdata,
  input  logic [IDX_W-1:0]  host_rd_addr,
  output logic              host_rd_bit,
  output logic [RTR_W-1:0]  host_rtaddr,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              verdict_valid,
  output logic              cmd_addressed,
  output logic              cmd_illegal,
  output logic              addr_err
);
  cmd_t             cmd;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_bit;
  logic             hit;
  logic             par_ok;
  logic             tbl_wr;
  logic             reg_wr;

  assign cmd    = cmd_t'(cmd_word);
  assign lk_idx = mk_index(cmd);
  assign tbl_wr = host_wr_en && host_wr_tbl;
  assign reg_wr = host_wr_en && !host_wr_tbl;

  rt_addr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(host_wdata),
    .cmd_rta(cmd.rta), .rtaddr(host_rtaddr), .par_ok(par_ok), .hit(hit)
  );

  ill_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(host_addr),
    .wr_bit(host_wdata[0]), .lookup(cmd_valid), .lk_idx(lk_idx),
    .lk_bit(lk_bit), .rd_idx(host_rd_addr), .rd_bit(host_rd_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      cmd_addressed <= 1'b0;
      cmd_illegal   <= 1'b0;
    end else begin
      verdict_valid <= cmd_valid;
      if (cmd_valid) begin
        cmd_addressed <= hit;
        cmd_illegal   <= hit && lk_bit;
      end
    end
  end

  assign addr_err = !par_ok;

  // R5: verdict pulse follows the strobe by one clock
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> verdict_valid);
  a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !verdict_valid);
  // R5: verdict holds between commands
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cmd_addressed) && $stable(cmd_illegal));
  // R4: illegal only for addressed commands
  a_r4_illegal_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> cmd_addressed);
  // R3: parity error at lookup time means not addressed
  a_r3_err_deaf: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && addr_err) |=> !cmd_addressed);
endmodule

// File: tb/sim_rt_illegal_chk.sv
module sim_rt_illegal_chk;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1553;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_wr_tbl = 1'b0;
  logic [11:0] host_addr = '0, host_rd_addr = '0;
  logic [5:0]  host_wdata = '0;
  logic        host_rd_bit;
  logic [5:0]  host_rtaddr;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        verdict_valid, cmd_addressed, cmd_illegal, addr_err;

  int nchk = 0, nfail = 0;
  bit model_tbl [4096];
  logic [5:0] model_rt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_illegal_chk u0 (.*);

  function automatic bit odd_ok(input logic [5:0] r);
    int n = 0;
    for (int i = 0; i < 6; i++) n += r[i];
    return (n % 2) == 1;
  endfunction

  function automatic int idx_of(input logic [15:0] c);
    int v = 0;
    if (c[15:11] == 5'd31) v += 2048;
    if (c[10]) v += 1024;
    v += int'(c[9:5]) * 32 + int'(c[4:0]);
    return v;
  endfunction

  function automatic bit exp_addr(input logic [15:0] c);
    return odd_ok(model_rt) && (c[15:11] == model_rt[4:0] || c[15:11] == 5'd31);
  endfunction

  function automatic logic [5:0] with_par(input logic [4:0] a);
    return {~(^a), a};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_tbl(input int idx, input bit v);
    host_wr_en = 1; host_wr_tbl = 1; host_addr = 12'(idx); host_wdata = {5'd0, v};
    @(negedge clk);
    host_wr_en = 0;
    model_tbl[idx] = v;
  endtask

  task automatic wr_rt(input logic [5:0] r);
    host_wr_en = 1; host_wr_tbl = 0; host_wdata = r;
    @(negedge clk);
    host_wr_en = 0;
    model_rt = r;
  endtask

  task automatic send(input logic [15:0] c, input string req);
    bit ea, ei;
    ea = exp_addr(c);
    ei = ea && model_tbl[idx_of(c)];
    cmd_valid = 1; cmd_word = c;
    @(negedge clk);
    cmd_valid = 0;
    chk(verdict_valid == 1, {req, " R5 pulse"}, verdict_valid, 1);
    chk(cmd_addressed == ea, {req, " R2 addressed"}, cmd_addressed, ea);
    chk(cmd_illegal == ei, {req, " R4 illegal"}, cmd_illegal, ei);
  endtask

  function automatic logic [15:0] mkc(input logic [4:0] a, input bit tr,
                                      input logic [4:0] sa, input logic [4:0] wc);
    return {a, tr, sa, wc};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk(verdict_valid == 0, "R9 verdict_valid", verdict_valid, 0);
    chk(cmd_addressed == 0 && cmd_illegal == 0, "R9 verdict", cmd_addressed, 0);
    chk(addr_err == 1, "R9 addr_err", addr_err, 1);
    chk(host_rtaddr == 0, "R9 rtaddr", host_rtaddr, 0);
    host_rd_addr = 12'd77;
    #1 chk(host_rd_bit == 0, "R9 table legal", host_rd_bit, 0);

    // R3: reset register is deaf even to broadcast
    send(mkc(5'd31, 0, 5'd1, 5'd2), "R3 reset deaf");

    // R8: program own address 5
    wr_rt(with_par(5'd5));
    chk(host_rtaddr == 6'b100101, "R8 readback", host_rtaddr, 6'b100101);
    chk(addr_err == 0, "R8 parity ok", addr_err, 0);
    send(mkc(5'd5, 1, 5'd3, 5'd4), "R2 own legal");

    // R1 R6: mark own-address entry illegal; index = tr*1024+sa*32+wc
    wr_tbl(1024 + 3*32 + 4, 1);
    host_rd_addr = 12'(1024 + 3*32 + 4);
    #1 chk(host_rd_bit == 1, "R6 readback", host_rd_bit, 1);
    send(mkc(5'd5, 1, 5'd3, 5'd4), "R1 own illegal");
    // R1: same fields via broadcast use the other half
    send(mkc(5'd31, 1, 5'd3, 5'd4), "R1 bcast legal");
    wr_tbl(2048 + 1024 + 3*32 + 4, 1);
    send(mkc(5'd31, 1, 5'd3, 5'd4), "R1 bcast illegal");
    // R2: other address is not addressed even if entry set
    send(mkc(5'd6, 1, 5'd3, 5'd4), "R2 other addr");
    // R5: hold after idle cycle
    @(negedge clk);
    chk(verdict_valid == 0, "R5 no pulse", verdict_valid, 0);
    chk(cmd_addressed == 0 && cmd_illegal == 0, "R5 hold", cmd_addressed, 0);

    // R7: write colliding with lookup of the same entry
    host_rd_addr = 12'(5*32 + 6);
    cmd_valid = 1; cmd_word = mkc(5'd5, 0, 5'd5, 5'd6);
    host_wr_en = 1; host_wr_tbl = 1; host_addr = 12'(5*32 + 6); host_wdata = 6'd1;
    @(negedge clk);
    cmd_valid = 0; host_wr_en = 0;
    chk(cmd_addressed == 1 && cmd_illegal == 0, "R7 lookup sees old", cmd_illegal, 0);
    chk(host_rd_bit == 0, "R7 deferred", host_rd_bit, 0);
    @(negedge clk);
    chk(host_rd_bit == 1, "R7 committed", host_rd_bit, 1);
    model_tbl[5*32 + 6] = 1;
    send(mkc(5'd5, 0, 5'd5, 5'd6), "R7 after commit");

    // R3: bad parity register
    wr_rt(6'b000101);
    chk(addr_err == 1, "R3 addr_err", addr_err, 1);
    send(mkc(5'd5, 1, 5'd3, 5'd4), "R3 own deaf");
    send(mkc(5'd31, 1, 5'd3, 5'd4), "R3 bcast deaf");
    wr_rt(with_par(5'd12));

    // random phase
    for (int it = 0; it < 600; it++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 25) begin
        wr_tbl(int'({$urandom_range(0,1), $urandom_range(0,1),
                     2'b0, 3'($urandom_range(0,3)), 2'b0, 3'($urandom_range(0,3))}) & 12'hFFF,
               1'($urandom_range(0,1)));
      end else if (sel < 32) begin
        if ($urandom_range(0,4) == 0) wr_rt(6'($urandom_range(0,63)));
        else wr_rt(with_par(5'($urandom_range(0,31))));
        chk(addr_err == !odd_ok(model_rt), "R3 random parity", addr_err, !odd_ok(model_rt));
      end else begin
        logic [4:0] a;
        int pick;
        pick = $urandom_range(0,2);
        a = (pick == 0) ? model_rt[4:0] : (pick == 1) ? 5'd31 : 5'($urandom_range(0,31));
        send(mkc(a, 1'($urandom_range(0,1)), 5'($urandom_range(0,3)),
                 5'($urandom_range(0,3))), "R4 random");
        host_rd_addr = 12'($urandom_range(0,4095));
        #1 chk(host_rd_bit == model_tbl[host_rd_addr], "R6 random readback",
               host_rd_bit, model_tbl[host_rd_addr]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule